// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a single timer channel with a count width of 16 bits by default. Its counter steps down by one on each pulse of a count-enable input. When a step is taken with the counter at zero, that step is an underflow: the counter loads the value held in a reload register instead of wrapping, and an underflow flag is set. The timer runs in one of two modes. In repeat mode it keeps counting, so it fires once every reload+1 count pulses. In one-shot mode the underflow also stops the timer. Clock selection and prescaling sit outside the block, and the count-enable input takes their place.

Software controls the timer through a small register port. A write takes effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. A master enable bit gates everything. A start bit and a load-now command act only when the master enable is already set or is set by the same write. The load-now command copies the reload value into the counter on the next count pulse. Its status bit reads 1 until that copy has been made. The interrupt output is the underflow flag masked by an interrupt-enable bit. Software clears the flag by writing 1 to it.

Top module: `reload_timer`

## Requirements
- R1: After reset the counter and the reload register read 0xFFFF, and the control and flag registers read 0. `irq` is 0.
- R2: Register addresses are 0 for control, 1 for reload (read/write), 2 for counter (read-only) and 3 for flag. The control bits are bit0 master enable, bit1 load-now, bit2 run, bit3 one-shot mode (1) or repeat mode (0), and bit4 interrupt enable. The flag register holds the underflow flag in bit0. All unused bits read 0.
- R3: A control write whose bit0 is 0 leaves run and load-now at 0, and a tick then leaves the counter unchanged. Such a write also stops a running timer and cancels a pending load.
- R4: A control write with bits 0 and 1 both set makes bit1 read 1. On the next count pulse the counter takes the reload value and bit1 reads 0. Writing 0 to bit1 does not cancel a pending load.
- R5: While running with no load pending, each count pulse lowers a nonzero counter by one. Without a pulse, the counter holds its value.
- R6: A count pulse with the counter at 0 while running loads the reload value and sets the underflow flag on the same edge.
- R7: In repeat mode the timer keeps running after an underflow and underflows again every reload+1 pulses. With a reload of 0 it underflows on every pulse.
- R8: In one-shot mode the run bit reads 0 after an underflow, and the counter then holds the reload value.
- R9: Writing 1 to flag bit0 clears the flag. Writing 0 has no effect. If an underflow and a clear fall on the same edge, the flag ends up set.
- R10: `irq` equals the underflow flag ANDed with control bit4.
- R11: Writing control with bit2 cleared and bit0 set stops counting, and the counter keeps its value through later pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count-enable pulse, one step per cycle high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same edge. The first is an underflow that sets the flag while software writes 1 to clear it. The bench lines up a count pulse at counter zero with a write of 1 to the flag register in the same cycle, and expects the flag to stay set. The second is a one-shot underflow that clears run while a control write sets it. The bench expects the write to win, so run reads back 1. A reference model in the bench sweeps every small reload value in both modes and predicts the counter, flag, run bit and interrupt after each pulse.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_FLAG   = 2'd3;
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_LOAD = 1;
  localparam int unsigned B_RUN  = 2;
  localparam int unsigned B_ONE  = 3;
  localparam int unsigned B_IE   = 4;
  localparam int unsigned CTRL_BITS = 5;

  typedef struct packed {
    logic ie;
    logic oneshot;
    logic run;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/reload_timer_regs.sv
module reload_timer_regs
  import reload_timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              uflow,
  output ctrl_t             ctrl,
  output logic [W-1:0]      reload,
  output logic              flag,
  output logic              load_req,
  output logic              load_drop
);
  logic ctrl_wr, flag_wr;
  assign ctrl_wr   = wr && (addr == A_CTRL);
  assign flag_wr   = wr && (addr == A_FLAG);
  assign load_req  = ctrl_wr && wdata[B_EN] && wdata[B_LOAD];
  assign load_drop = ctrl_wr && !wdata[B_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '1;
      flag   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl.en      <= wdata[B_EN];
        ctrl.run     <= wdata[B_EN] && wdata[B_RUN];
        ctrl.oneshot <= wdata[B_ONE];
        ctrl.ie      <= wdata[B_IE];
      end else if (uflow && ctrl.oneshot) begin
        ctrl.run <= 1'b0;
      end
      if (wr && (addr == A_RELOAD)) reload <= wdata;
      if (uflow) flag <= 1'b1;
      else if (flag_wr && wdata[0]) flag <= 1'b0;
    end
  end

  // R3: run can only be held while the master enable is set
  a_r3_run_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.run |-> ctrl.en);
  // R8: one-shot underflow without a competing control write stops the timer
  a_r8_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && ctrl.oneshot && !ctrl_wr) |=> !ctrl.run);
  // R9: underflow always leaves the flag set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> flag);
endmodule

// File: rtl/reload_timer_core.sv
module reload_timer_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic         run,
  input  logic [W-1:0] reload,
  input  logic         load_req,
  input  logic         load_drop,
  output logic [W-1:0] cnt,
  output logic         pend,
  output logic         uflow
);
  localparam logic [W-1:0] ZERO = '0;
  logic step;
  assign step  = tick && en;
  assign uflow = step && !pend && run && (cnt == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '1;
      pend <= 1'b0;
    end else begin
      if (step && pend) begin
        cnt  <= reload;
        pend <= 1'b0;
      end else if (step && run) begin
        cnt <= (cnt == ZERO) ? reload : cnt - 1'b1;
      end
      if (load_req) pend <= 1'b1;
      else if (load_drop) pend <= 1'b0;
    end
  end

  // R4: a pending load completes on the next count pulse
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pend && !load_req) |=> (cnt == $past(reload)) && !pend);
  // R5: decrement by one on a count pulse
  a_r5_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (step && run && !pend && cnt != ZERO) |=> cnt == $past(cnt) - 1'b1);
  // R5: no pulse, no change
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));
  // R6: underflow loads the reload value
  a_r6_uflow_load: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> cnt == $past(reload));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              irq
);
  ctrl_t        ctrl;
  logic [W-1:0] reload, cnt;
  logic         flag, load_req, load_drop, pend, uflow;

  reload_timer_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .uflow(uflow), .ctrl(ctrl), .reload(reload), .flag(flag),
    .load_req(load_req), .load_drop(load_drop)
  );

  reload_timer_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .en(ctrl.en), .run(ctrl.run),
    .reload(reload), .load_req(load_req), .load_drop(load_drop),
    .cnt(cnt), .pend(pend), .uflow(uflow)
  );

  logic [CTRL_BITS-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd         = '0;
    ctrl_rd[B_EN]   = ctrl.en;
    ctrl_rd[B_LOAD] = pend;
    ctrl_rd[B_RUN]  = ctrl.run;
    ctrl_rd[B_ONE]  = ctrl.oneshot;
    ctrl_rd[B_IE]   = ctrl.ie;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata[CTRL_BITS-1:0] = ctrl_rd;
      A_RELOAD: reg_rdata = reload;
      A_COUNT:  reg_rdata = cnt;
      default:  reg_rdata[0] = flag;
    endcase
  end

  assign irq = flag && ctrl.ie;

  // R10: an interrupt is never raised without a pending flag
  a_r10_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

// File: tb/reload_timer_tb.sv
module reload_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [15:0] EN = 16'h1, LD = 16'h2, RUN = 16'h4, ONE = 16'h8, IE = 16'h10;

  reload_timer u_dut (.clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk); cnt_tick = 1'b1;
    @(negedge clk); cnt_tick = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd2, v); chk("R1 count", v, 16'hFFFF);
    rd(2'd1, v); chk("R1 reload", v, 16'hFFFF);
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
    rd(2'd3, v); chk("R1 flag", v, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R3 gating: no enable, run and load ignored
    wr(2'd1, 16'h0005);
    wr(2'd0, RUN | LD);
    rd(2'd0, v); chk("R3 ctrl ignored", v, 16'h0);
    tick();
    rd(2'd2, v); chk("R3 count held", v, 16'hFFFF);
    // R4 load-now pending, write 0 keeps pending, R3 drop on disable
    wr(2'd0, EN | LD);
    rd(2'd0, v); chk("R4 pending reads 1", v, EN | LD);
    wr(2'd0, EN);
    rd(2'd0, v); chk("R4 write0 no cancel", v, EN | LD);
    wr(2'd0, 16'h0);
    rd(2'd0, v); chk("R3 disable drops load", v, 16'h0);
    wr(2'd0, EN);
    tick();
    rd(2'd2, v); chk("R3 no load after drop", v, 16'hFFFF);

    // R2 count register read-only
    wr(2'd2, 16'h1234);
    rd(2'd2, v); chk("R2 count read-only", v, 16'hFFFF);

    // Sweep: both modes, small reload values
    for (int m = 0; m < 2; m++) begin
      for (int rl = (m == 1) ? 1 : 0; rl <= 6; rl++) begin
        logic [15:0] mb, c;
        logic f, r;
        mb = (m == 1) ? ONE : 16'h0;
        wr(2'd3, 16'h1);
        wr(2'd1, 16'(rl));
        wr(2'd0, EN | LD | mb | IE);
        rd(2'd0, v); chk("R4 sweep pending", v, EN | LD | mb | IE);
        tick();
        rd(2'd2, v); chk("R4 sweep loaded", v, 16'(rl));
        rd(2'd0, v); chk("R4 sweep load done", v, EN | mb | IE);
        wr(2'd0, EN | RUN | mb | IE);
        c = 16'(rl); f = 1'b0; r = 1'b1;
        for (int k = 0; k < 2 * (rl + 1) + 1; k++) begin
          tick();
          if (r) begin
            if (c == 0) begin c = 16'(rl); f = 1'b1; if (m == 1) r = 1'b0; end
            else c = c - 1;
          end
          rd(2'd2, v); chk((m == 1) ? "R8 sweep count" : "R7 sweep count", v, c);
          rd(2'd3, v); chk("R6 sweep flag", v, {15'b0, f});
          rd(2'd0, v); chk("R8 sweep run", v, EN | mb | IE | (r ? RUN : 16'h0));
          chk("R10 sweep irq", {15'b0, irq}, {15'b0, f});
        end
      end
    end

    // R10 mask off
    wr(2'd0, EN);
    chk("R10 irq masked", {15'b0, irq}, 16'h0);
    // R9 write 0 no effect, write 1 clears
    wr(2'd3, 16'h0);
    rd(2'd3, v); chk("R9 write0 keeps", v, 16'h1);
    wr(2'd3, 16'h1);
    rd(2'd3, v); chk("R9 write1 clears", v, 16'h0);

    // R9 collision: reload 1, repeat mode
    wr(2'd1, 16'h0001);
    wr(2'd0, EN | LD);
    tick();
    wr(2'd0, EN | RUN);
    tick();
    rd(2'd2, v); chk("R5 at zero", v, 16'h0);
    @(negedge clk);
    cnt_tick = 1'b1; reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h1;
    @(negedge clk);
    cnt_tick = 1'b0; reg_wr = 1'b0;
    rd(2'd3, v); chk("R9 set wins", v, 16'h1);
    rd(2'd2, v); chk("R6 reloaded", v, 16'h1);

    // R5 hold with no pulse
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk("R5 idle hold", v, 16'h1);
    // R11 stop holds count
    wr(2'd1, 16'h0009);
    wr(2'd0, EN | LD | RUN);
    tick(); tick(); tick();
    rd(2'd2, v); chk("R11 before stop", v, 16'h7);
    wr(2'd0, EN);
    tick(); tick();
    rd(2'd2, v); chk("R11 held after stop", v, 16'h7);

    // One-shot underflow vs same-edge control write: write wins
    wr(2'd1, 16'h0001);
    wr(2'd0, EN | LD | RUN | ONE);
    tick(); tick();
    rd(2'd2, v); chk("R8 oneshot at zero", v, 16'h0);
    @(negedge clk);
    cnt_tick = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = EN | RUN | ONE;
    @(negedge clk);
    cnt_tick = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); chk("R8 write beats auto stop", v, EN | RUN | ONE);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule